// File: doc/BRIEF.md
# Periodic Tick Timer

A word-addressed, memory-mapped down-counter that produces a regular timing event. Software loads a reload value, optionally picks the counting source, and enables the timer. The counter steps down once per tick. A tick is either every processor clock cycle or each cycle in which an external reference-tick enable is high. When the count steps from 1 to 0 the block sets a sticky count flag and, if interrupts are enabled, pulses an interrupt request for one cycle. On the next tick it reloads, so one period spans reload+1 ticks.

The counting behaviour is held in a small state machine with three states. `ST_OFF` is the disabled state. `ST_LOAD` means the timer is enabled with a count of zero and waits for a tick to reload. `ST_RUN` means the timer is enabled with a nonzero count and steps down. Its transitions are as follows:
- *enable* moves from `ST_OFF` to `ST_LOAD` or `ST_RUN`, depending on whether the count is zero.
- *disable* moves from any state to `ST_OFF`.
- *reload* moves from `ST_LOAD` to `ST_RUN` when the reload value is nonzero, and stays in `ST_LOAD` when it is zero.
- *expire* moves from `ST_RUN` to `ST_LOAD` on the 1-to-0 step.
- *clear* is a write to the current-value word. It zeroes the count and goes to `ST_LOAD` while enabled, or to `ST_OFF` while disabled.

A read-only calibration word reports a count for 10 ms, a skew flag and a flag for a missing reference clock. All three are set by parameters.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word reads 0, except that the clock-select bit reads the value of `NO_REF`. The reload and current words read 0 and `irq` is low.
- R2: The block decodes four words:
  - Word 3 is the calibration word.
  - Word 2 is the current count.
  - Word 1 is the reload value in bits [CNT_W-1:0]; bits above it read 0.
  - Word 0 is control. Bit 16 is the count flag, which writes cannot change. Bit 2 is clock-select (1 = processor clock). Bit 1 is the interrupt enable and bit 0 is the enable. All other control bits read 0.
- R3: With clock-select 1, enabling from a zero count loads the reload value on the first cycle. The count then reaches 0 every reload+1 cycles, and `irq` is high for exactly the one cycle after each 1-to-0 step when the interrupt enable is 1.
- R4: With the interrupt enable at 0, `irq` stays low, but the count flag is still set on each 1-to-0 step.
- R5: A read of word 0 returns the count flag and then clears it. When a 1-to-0 step occurs in the same cycle as that read, the flag stays set.
- R6: Any write to word 2 zeroes the count and clears the count flag, and it takes priority over a tick in that cycle. While enabled, the next tick loads the reload value.
- R7: Loading the reload value from a zero count does not set the count flag.
- R8: With a reload value of 0, an enabled timer keeps a count of 0 and produces no event.
- R9: With clock-select 0, the count changes only in cycles where `ref_tick` is high.
- R10: With the enable at 0, the count holds its value.
- R11: Word 3 reads {NO_REF at bit 31, SKEW at bit 30, zeros, CAL_COUNT in bits [CNT_W-1:0]}. Writes to word 3 are ignored.
- R12: With `NO_REF`=1, the clock-select bit reads 1 even after a 0 has been written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick enable, used when clock-select is 0 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of word 0 clears the count flag |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, valid while `rd_en` is high |
| irq | output | 1 | One-cycle interrupt request on each 1-to-0 step |

## Verification
The properties assume that a read and a write never share a cycle. They also assume that a write to the current word and a write to control never coincide, which a single address makes impossible. Under those assumptions the count can change only on a tick or on a clear, an `irq` pulse always lands on a zero count with the flag already set, and it is never followed by a second pulse. The stimulus issues one bus operation per cycle. It toggles `ref_tick` only while the reference source is selected, and it spaces reads so that a flag-clearing read meets an expiry in one deliberate case only.

// File: rtl/tick_pkg.sv
package tick_pkg;
    // Word addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LOAD = 2'd1;
    localparam logic [1:0] ADDR_CUR  = 2'd2;
    localparam logic [1:0] ADDR_CAL  = 2'd3;

    // Control word bit positions
    localparam int BIT_EN     = 0;
    localparam int BIT_IRQ_EN = 1;
    localparam int BIT_CLKSEL = 2;
    localparam int BIT_FLAG   = 16;

    // Calibration word bit positions
    localparam int BIT_SKEW  = 30;
    localparam int BIT_NOREF = 31;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } tick_state_e;

    typedef struct packed {
        logic en;
        logic irq_en;
        logic clk_sel;
    } tick_ctrl_t;
endpackage

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter bit NO_REF = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             evt,
    input  logic [CNT_W-1:0] cur_val,
    input  logic [31:0]      calib,
    output tick_ctrl_t       ctrl,
    output logic [CNT_W-1:0] reload,
    output logic             ctrl_wr,
    output logic             cur_wr,
    output logic             flag,
    output logic [31:0]      rdata
);
    localparam int PAD_W = 32 - CNT_W;

    logic en_q;
    logic irq_en_q;
    logic clk_sel_q;
    logic status_rd;

    assign ctrl_wr   = wr_en && (addr == ADDR_CTRL);
    assign cur_wr    = wr_en && (addr == ADDR_CUR);
    assign status_rd = rd_en && (addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            irq_en_q <= 1'b0;
            reload   <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q     <= wdata[BIT_EN];
                irq_en_q <= wdata[BIT_IRQ_EN];
            end
            if (wr_en && (addr == ADDR_LOAD)) begin
                reload <= wdata[CNT_W-1:0];
            end
        end
    end

    generate
        if (NO_REF) begin : g_forced_clk
            assign clk_sel_q = 1'b1;
        end else begin : g_free_clk
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_sel_q <= 1'b0;
                end else if (ctrl_wr) begin
                    clk_sel_q <= wdata[BIT_CLKSEL];
                end
            end
        end
    endgenerate

    // Sticky count flag: an expiry beats a clearing read in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (evt) begin
            flag <= 1'b1;
        end else if (cur_wr || status_rd) begin
            flag <= 1'b0;
        end
    end

    assign ctrl = '{en: en_q, irq_en: irq_en_q, clk_sel: clk_sel_q};

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                ADDR_CTRL: begin
                    rdata[BIT_EN]     = en_q;
                    rdata[BIT_IRQ_EN] = irq_en_q;
                    rdata[BIT_CLKSEL] = clk_sel_q;
                    rdata[BIT_FLAG]   = flag;
                end
                ADDR_LOAD: rdata = {{PAD_W{1'b0}}, reload};
                ADDR_CUR:  rdata = {{PAD_W{1'b0}}, cur_val};
                default:   rdata = calib;
            endcase
        end
    end
endmodule

// File: rtl/tick_fsm.sv
module tick_fsm
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             ctrl_wr,
    input  logic             en_wdata,
    input  logic             cur_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             evt,
    output tick_state_e      state
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tick_state_e      state_n;
    logic [CNT_W-1:0] cnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state, next count and the expiry event
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        evt     = 1'b0;
        unique case (state)
            ST_OFF: begin
            end
            ST_LOAD: begin
                if (tick) begin
                    cnt_n   = reload;
                    state_n = (reload != '0) ? ST_RUN : ST_LOAD;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    cnt_n = cnt - ONE;
                    if (cnt == ONE) begin
                        evt     = 1'b1;
                        state_n = ST_LOAD;
                    end
                end
            end
            default: state_n = ST_OFF;
        endcase

        // clear: a write to the current word wins over the tick
        if (cur_wr) begin
            cnt_n   = '0;
            evt     = 1'b0;
            state_n = (state == ST_OFF) ? ST_OFF : ST_LOAD;
        end

        // enable / disable
        if (ctrl_wr) begin
            if (!en_wdata) begin
                state_n = ST_OFF;
            end else if (state == ST_OFF) begin
                state_n = (cnt == '0) ? ST_LOAD : ST_RUN;
            end
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int          CNT_W     = 24,
    parameter logic [23:0] CAL_COUNT = 24'h0,
    parameter bit          SKEW      = 1'b0,
    parameter bit          NO_REF    = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    localparam int CAL_W = (CNT_W < 24) ? CNT_W : 24;

    tick_ctrl_t       ctrl_w;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] cur_w;
    logic             ctrl_wr_w;
    logic             cur_wr_w;
    logic             flag_w;
    logic             evt_w;
    logic             tick_w;
    logic             en_w;
    logic             irq_en_w;
    logic [31:0]      calib_w;
    tick_state_e      state_w;

    always_comb begin
        calib_w               = '0;
        calib_w[CAL_W-1:0]    = CAL_COUNT[CAL_W-1:0];
        calib_w[BIT_SKEW]     = SKEW;
        calib_w[BIT_NOREF]    = NO_REF;
    end

    assign en_w     = ctrl_w.en;
    assign irq_en_w = ctrl_w.irq_en;
    assign tick_w   = ctrl_w.clk_sel ? 1'b1 : ref_tick;

    tick_regs #(
        .CNT_W  (CNT_W),
        .NO_REF (NO_REF)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .evt     (evt_w),
        .cur_val (cur_w),
        .calib   (calib_w),
        .ctrl    (ctrl_w),
        .reload  (reload_w),
        .ctrl_wr (ctrl_wr_w),
        .cur_wr  (cur_wr_w),
        .flag    (flag_w),
        .rdata   (rdata)
    );

    tick_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .reload   (reload_w),
        .ctrl_wr  (ctrl_wr_w),
        .en_wdata (wdata[BIT_EN]),
        .cur_wr   (cur_wr_w),
        .cnt      (cur_w),
        .evt      (evt_w),
        .state    (state_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= evt_w && irq_en_w;
        end
    end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             flag,
    input logic             irq_en,
    input logic             en,
    input logic             tick,
    input logic             cur_wr,
    input logic [CNT_W-1:0] cur_val
);
    // R3
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cur_val == '0));

    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    // R5
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R6
    cur_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cur_val == '0));

    // R9
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cur_wr) |=> $stable(cur_val));

    // R10
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cur_wr) |=> $stable(cur_val));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .flag    (flag_w),
    .irq_en  (irq_en_w),
    .en      (en_w),
    .tick    (tick_w),
    .cur_wr  (cur_wr_w),
    .cur_val (cur_w)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        sel;
        logic [31:0] mask;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] rdata_nr;
    logic        irq;
    logic        irq_nr;

    int checks = 0;
    int errors = 0;
    sb_item_t sb[$];
    sb_item_t cur_item;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer #(.CAL_COUNT(24'h001234), .SKEW(1'b1), .NO_REF(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    tick_timer #(.CAL_COUNT(24'h000100), .SKEW(1'b0), .NO_REF(1'b1)) u_nref (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata_nr), .irq(irq_nr)
    );

    // Monitor: pops one expectation per read cycle
    always @(negedge clk) begin
        if (rd_en) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: read with no expectation");
            end else begin
                cur_item = sb.pop_front();
                if (((cur_item.sel ? rdata_nr : rdata) & cur_item.mask) !== cur_item.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", cur_item.tag,
                             (cur_item.sel ? rdata_nr : rdata) & cur_item.mask, cur_item.exp);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic sel, input logic [31:0] mask,
                      input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.sel = sel; it.mask = mask; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R11 calibration, R12 forced clock-select
        chk({31'd0, irq}, 32'd0, "R1 irq low after reset");
        rd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0, "R1 control after reset");
        rd(2'd1, 1'b0, 32'hFFFF_FFFF, 32'h0, "R1 reload after reset");
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'h0, "R1 current after reset");
        rd(2'd0, 1'b1, 32'hFFFF_FFFF, 32'h4, "R12 clock-select reads 1 without reference");
        rd(2'd3, 1'b0, 32'hFFFF_FFFF, 32'h4000_1234, "R11 calibration word");
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, 1'b0, 32'hFFFF_FFFF, 32'h4000_1234, "R11 calibration write ignored");
        rd(2'd3, 1'b1, 32'h8000_0000, 32'h8000_0000, "R11 no-reference flag");

        // R2 reload field width
        wr(2'd1, 32'hFFAB_CDEF);
        rd(2'd1, 1'b0, 32'hFFFF_FFFF, 32'h00AB_CDEF, "R2 reload upper bits read zero");

        // R3 period reload+1 with interrupt
        wr(2'd1, 32'd4);
        wr(2'd2, 32'h55);
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'h0, "R6 current after write");
        wr(2'd0, 32'h7);
        for (int k = 1; k <= 11; k++) begin
            @(posedge clk); #1;
            chk({31'd0, irq}, ((k == 5) || (k == 10)) ? 32'd1 : 32'd0, "R3 irq timing");
        end
        wr(2'd0, 32'h6);
        rd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0001_0006, "R5 flag set after expiry");
        rd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0006, "R5 flag cleared by read");
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'd3, "R10 count at disable");
        idle(5);
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'd3, "R10 count holds while disabled");

        // R4 no interrupt when disabled in control, flag still set
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h5);
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); #1;
            chk({31'd0, irq}, 32'd0, "R4 irq stays low");
        end
        wr(2'd0, 32'h4);
        rd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0001_0004, "R4 flag set without irq");
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'd2, "R4 count after reload");

        // R5 expiry in the same cycle as a clearing read
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h5);
        idle(3);
        rd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0005, "R5 flag clear before expiry");
        rd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0001_0005, "R5 expiry beats clearing read");
        rd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0005, "R5 flag cleared afterwards");
        wr(2'd0, 32'h4);
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'd1, "R10 count after disable");

        // R6 clear while running, R7 load without event
        wr(2'd0, 32'h5);
        wr(2'd2, 32'hDEAD_BEEF);
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'd0, "R6 write clears running count");
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'd3, "R6 next tick loads reload");
        rd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0005, "R7 load sets no flag");
        wr(2'd0, 32'h4);

        // R8 reload of zero
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h7);
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); #1;
            chk({31'd0, irq}, 32'd0, "R8 no irq with zero reload");
        end
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'd0, "R8 count stays zero");
        rd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0007, "R8 no flag with zero reload");
        wr(2'd0, 32'h0);

        // R9 reference tick source
        wr(2'd1, 32'd5);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h1);
        idle(4);
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'd0, "R9 no count without reference tick");
        ref_tick = 1'b1;
        idle(3);
        ref_tick = 1'b0;
        rd(2'd2, 1'b0, 32'hFFFF_FFFF, 32'd3, "R9 three reference ticks");
        wr(2'd0, 32'h0);

        // R2 reserved control bits, R12 clock-select cannot clear
        wr(2'd0, 32'hFFFE_FFF8);
        rd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0, "R2 reserved control bits read zero");
        rd(2'd0, 1'b1, 32'h0000_0007, 32'h4, "R12 clock-select stays 1 after writing 0");

        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule